// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out coherence maintenance that software asks for, one cache line at a time, through the tag and eviction port of a cache. Three kinds of operation are offered: invalidate, which drops a line without writing anything back; writeback, which pushes a dirty line to the next memory level and leaves it valid; and writeback-then-invalidate. Each kind can be aimed at an address range or at every line frame of the cache.

Software reaches the block through a small write-only register port. One register holds the starting word address and another holds the operation kind and the target cache (data side or program side). Two further selects start the work. Writing a word count starts a range operation. Writing the sweep select starts a whole-cache operation. The range is widened outward to whole lines. A busy flag is high from the start until the cache acknowledges the last line command. Register writes that arrive while the block is busy are dropped.

The program-side cache takes invalidates only. Writeback requests aimed at it are refused and produce no activity.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy_o and cmd_valid_o are low.
- R2: A write to select 2 (word count) while idle starts a range operation. busy_o and cmd_valid_o are high from the clock edge that takes the write. Select 0 holds the base word address. Select 1 holds the operation in bits [1:0] (1 = invalidate, 2 = writeback, 3 = writeback-then-invalidate, 0 = none, which starts nothing) and the target in bit 2 (0 = data, 1 = program).
- R3: A range operation visits line addresses floor(base/LINE_WORDS) up to floor((base+count-1)/LINE_WORDS) in ascending order, once each, with cmd_frame_o low.
- R4: A word count of zero completes at once. No command is issued and busy_o stays low.
- R5: Invalidate issues one command per line with cmd_wb_o low.
- R6: Writeback issues one command per line with cmd_wb_o high.
- R7: Writeback-then-invalidate issues, for each line, a command with cmd_wb_o high. Only after that command is acknowledged does it issue a command with cmd_wb_o low for the same line.
- R8: A write to select 3 while idle sweeps frame indices 0 to NUM_FRAMES-1 in ascending order on cmd_line_o, with cmd_frame_o high.
- R9: With the program target chosen, invalidate runs normally with cmd_prog_o high. Writeback and writeback-then-invalidate start nothing, and busy_o stays low.
- R10: busy_o stays high until the acknowledge of the last command. Register writes while busy_o is high change no register and start nothing.
- R11: While cmd_valid_o is high and cmd_ack_i is low, the command fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 base, 1 control, 2 count/start, 3 sweep start |
| reg_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Operation in progress |
| cmd_valid_o | output | 1 | Line command offered to the cache |
| cmd_wb_o | output | 1 | 1 = writeback command, 0 = invalidate command |
| cmd_prog_o | output | 1 | Command targets the program-side cache |
| cmd_frame_o | output | 1 | cmd_line_o carries a frame index, not a line address |
| cmd_line_o | output | LINE_AW | Line address or frame index |
| cmd_ack_i | input | 1 | Cache accepts and completes the offered command |

## Verification
The first line command and busy_o appear right after the clock edge that takes the starting write. The bench samples them on the next falling edge. Each command is retired on the edge where cmd_ack_i is high, and the next command, or busy_o low after the last one, is visible one cycle later. The bench therefore acts as the cache on falling edges, logs each command when it acknowledges it, and compares the whole log with a list computed from the range formula once busy_o falls. A slow-acknowledge mode holds each command for two extra cycles, to check that its fields stay steady and that register writes made during the operation have no effect.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_INV   = 2'd1,
    OP_WB    = 2'd2,
    OP_WBINV = 2'd3
  } cme_op_e;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_GLOB = 2'd3;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
  import cme_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] base_o,
  output cme_op_e           op_o,
  output logic              prog_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              start_part_o,
  output logic              start_glob_o
);
  logic accept;
  logic unused_wdata;

  assign accept       = we_i && !busy_i;
  assign count_o      = wdata_i[CNT_W-1:0];
  assign start_part_o = accept && (sel_i == SEL_CNT);
  assign start_glob_o = accept && (sel_i == SEL_GLOB);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      op_o   <= OP_NONE;
      prog_o <= 1'b0;
    end else if (accept) begin
      if (sel_i == SEL_BASE) base_o <= wdata_i[ADDR_W-1:0];
      if (sel_i == SEL_CTRL) begin
        op_o   <= cme_op_e'(wdata_i[1:0]);
        prog_o <= wdata_i[2];
      end
    end
  end

  // R10: configuration frozen while a walk runs
  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && we_i |=> $stable(base_o) && $stable(op_o) && $stable(prog_o));
endmodule

// File: rtl/cme_range.sv
module cme_range #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 4,
  parameter int CW     = 29,
  localparam int LAW   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [LAW-1:0]    first_line_o,
  output logic [CW-1:0]     n_lines_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] end_word;
  logic [LAW-1:0]    last_line;
  logic [LAW-1:0]    span;

  // inclusive last word; lines touched at either end count in full
  assign end_word     = base_i + ADDR_W'(count_i) - 1'b1;
  assign first_line_o = base_i[ADDR_W-1:OFF_W];
  assign last_line    = end_word[ADDR_W-1:OFF_W];
  assign span         = last_line - first_line_o;
  assign n_lines_o    = CW'(span) + 1'b1;
  assign empty_o      = (count_i == '0);
endmodule

// File: rtl/cme_walker.sv
module cme_walker
  import cme_pkg::*;
#(
  parameter int LAW        = 28,
  parameter int CW         = 29,
  parameter int NUM_FRAMES = 256
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_part_i,
  input  logic           start_glob_i,
  input  cme_op_e        op_i,
  input  logic           prog_i,
  input  logic [LAW-1:0] first_line_i,
  input  logic [CW-1:0]  n_lines_i,
  input  logic           empty_i,
  output logic           busy_o,
  output logic           cmd_valid_o,
  output logic           cmd_wb_o,
  output logic           cmd_prog_o,
  output logic           cmd_frame_o,
  output logic [LAW-1:0] cmd_line_o,
  input  logic           cmd_ack_i
);
  logic           busy_q, prog_q, frame_q, phase_q;
  cme_op_e        op_q;
  logic [LAW-1:0] line_q;
  logic [CW-1:0]  left_q;
  logic           legal, go_part, go_glob, second_half;

  // program side takes invalidate only
  assign legal   = (op_i != OP_NONE) && !(prog_i && op_i != OP_INV);
  assign go_part = start_part_i && legal && !empty_i;
  assign go_glob = start_glob_i && legal;
  assign second_half = (op_q == OP_WBINV) && !phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      op_q    <= OP_NONE;
      prog_q  <= 1'b0;
      frame_q <= 1'b0;
      phase_q <= 1'b0;
      line_q  <= '0;
      left_q  <= '0;
    end else if (!busy_q) begin
      if (go_part || go_glob) begin
        busy_q  <= 1'b1;
        op_q    <= op_i;
        prog_q  <= prog_i;
        frame_q <= go_glob;
        phase_q <= 1'b0;
        line_q  <= go_glob ? '0 : first_line_i;
        left_q  <= go_glob ? CW'(NUM_FRAMES) : n_lines_i;
      end
    end else if (cmd_ack_i) begin
      if (second_half) begin
        phase_q <= 1'b1;  // writeback done, invalidate same line next
      end else begin
        phase_q <= 1'b0;
        if (left_q == CW'(1)) busy_q <= 1'b0;
        else begin
          line_q <= line_q + 1'b1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign cmd_valid_o = busy_q;
  assign cmd_wb_o    = (op_q == OP_WB) || second_half;
  assign cmd_prog_o  = prog_q;
  assign cmd_frame_o = frame_q;
  assign cmd_line_o  = line_q;

  p_hold_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_line_o)
                                   && $stable(cmd_wb_o) && $stable(cmd_frame_o));
  p_wb_then_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ack_i && cmd_wb_o && op_q == OP_WBINV
      |=> cmd_valid_o && !cmd_wb_o && $stable(cmd_line_o));
  p_prog_inv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_prog_o |-> !cmd_wb_o);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ack_i && !second_half
      |=> !cmd_valid_o || cmd_line_o == $past(cmd_line_o) + 1'b1);
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int  ADDR_W     = 32,
  parameter int  CNT_W      = 16,
  parameter int  LINE_WORDS = 16,
  parameter int  NUM_FRAMES = 256,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int LINE_AW    = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  output logic               busy_o,
  output logic               cmd_valid_o,
  output logic               cmd_wb_o,
  output logic               cmd_prog_o,
  output logic               cmd_frame_o,
  output logic [LINE_AW-1:0] cmd_line_o,
  input  logic               cmd_ack_i
);
  localparam int FCW = $clog2(NUM_FRAMES + 1);
  localparam int CW  = (FCW > LINE_AW + 1) ? FCW : LINE_AW + 1;

  logic [ADDR_W-1:0]  base;
  cme_op_e            op;
  logic               prog;
  logic [CNT_W-1:0]   count;
  logic               start_part, start_glob, empty;
  logic [LINE_AW-1:0] first_line;
  logic [CW-1:0]      n_lines;

  cme_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(32)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o),
    .base_o(base), .op_o(op), .prog_o(prog), .count_o(count),
    .start_part_o(start_part), .start_glob_o(start_glob)
  );

  cme_range #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .CW(CW)) u_range (
    .base_i(base), .count_i(count),
    .first_line_o(first_line), .n_lines_o(n_lines), .empty_o(empty)
  );

  cme_walker #(.LAW(LINE_AW), .CW(CW), .NUM_FRAMES(NUM_FRAMES)) u_walker (
    .clk_i, .rst_ni,
    .start_part_i(start_part), .start_glob_i(start_glob),
    .op_i(op), .prog_i(prog),
    .first_line_i(first_line), .n_lines_i(n_lines), .empty_i(empty),
    .busy_o, .cmd_valid_o, .cmd_wb_o, .cmd_prog_o, .cmd_frame_o, .cmd_line_o,
    .cmd_ack_i
  );

  p_zero_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i == SEL_CNT && !busy_o && reg_wdata_i[CNT_W-1:0] == '0
      |=> !busy_o);
endmodule

// File: tb/cache_maint_engine_tb.sv
`timescale 1ns/1ps
module cache_maint_engine_tb;
  localparam int LAW = 28;
  localparam int NF  = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, ack = 1'b0;
  logic [1:0] sel = '0;
  logic [31:0] wdata = '0;
  logic busy_o, cmd_valid_o, cmd_wb_o, cmd_prog_o, cmd_frame_o;
  logic [LAW-1:0] cmd_line_o;

  int n_chk = 0, n_err = 0;
  bit slow = 1'b0, done = 1'b0;
  int log_n = 0;
  logic [LAW+2:0] log_e [0:1023];

  always #2.5 clk = ~clk;

  cache_maint_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .busy_o, .cmd_valid_o, .cmd_wb_o, .cmd_prog_o, .cmd_frame_o, .cmd_line_o,
    .cmd_ack_i(ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // cache stand-in: acknowledges on falling edges, logs accepted commands
  initial begin
    int wait_cnt;
    logic [LAW+2:0] cur, snap;
    wait_cnt = 0; snap = '0;
    forever begin
      @(negedge clk);
      cur = {cmd_prog_o, cmd_frame_o, cmd_wb_o, cmd_line_o};
      if (cmd_valid_o) begin
        if (slow && wait_cnt < 2) begin
          if (wait_cnt == 0) snap = cur;
          else chk(cur == snap, "R11 hold", 32'(cur), 32'(snap));
          wait_cnt++;
          ack = 1'b0;
        end else begin
          if (slow) chk(cur == snap, "R11 hold", 32'(cur), 32'(snap));
          if (log_n < 1024) log_e[log_n] = cur;
          log_n++;
          ack = 1'b1;
          wait_cnt = 0;
        end
      end else begin
        ack = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle(input string req, input int exp_n);
    int guard = 0;
    while (busy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy_o, req, 32'(busy_o), 0);
    chk(log_n == exp_n, req, 32'(log_n), 32'(exp_n));
  endtask

  // op: 1 inv, 2 wb, 3 wbinv
  task automatic cmp_log(input string req, input int lines, input logic [LAW-1:0] first,
                         input int op, input bit prog, input bit frame);
    int bad = 0;
    int n = (op == 3) ? 2 * lines : lines;
    logic [LAW+2:0] e, first_act, first_exp;
    first_act = '0; first_exp = '0;
    for (int i = 0; i < n && i < 1024; i++) begin
      logic [LAW-1:0] ln;
      logic wb;
      ln = first + LAW'((op == 3) ? i / 2 : i);
      wb = (op == 2) || (op == 3 && (i % 2) == 0);
      e  = {prog, frame, wb, ln};
      if (log_e[i] !== e) begin
        if (bad == 0) begin first_act = log_e[i]; first_exp = e; end
        bad++;
      end
    end
    chk(bad == 0, req, 32'(first_act), 32'(first_exp));
  endtask

  task automatic run_range(input string req, input logic [31:0] base, input int cnt,
                           input int op, input bit prog);
    logic [LAW-1:0] f, l;
    int lines;
    f = base[31:4];
    l = 28'((base + 32'(cnt) - 1) >> 4);
    lines = int'(l - f) + 1;
    log_n = 0;
    wr(2'd0, base);
    wr(2'd1, {29'd0, prog, 2'(op)});
    wr(2'd2, 32'(cnt));
    chk(busy_o && cmd_valid_o, {req, " R2 start"}, {30'd0, busy_o, cmd_valid_o}, 32'h3);
    wait_idle({req, " R10 end"}, (op == 3) ? 2 * lines : lines);
    cmp_log({req, " R3 order"}, lines, f, op, prog, 1'b0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !cmd_valid_o, "R1 reset", {30'd0, busy_o, cmd_valid_o}, 0);
  endtask

  task automatic t_inv;
    run_range("R5 inv unaligned", 32'h35, 40, 1, 1'b0);   // lines 3..5
    run_range("R5 inv single", 32'h1F, 1, 1, 1'b0);       // line 1
  endtask

  task automatic t_wb;
    run_range("R6 wb aligned", 32'h100, 32, 2, 1'b0);     // lines 16,17
    run_range("R6 wb straddle", 32'h10F, 2, 2, 1'b0);     // lines 16,17
  endtask

  task automatic t_wbinv;
    slow = 1'b1;
    run_range("R7 wbinv", 32'h20, 17, 3, 1'b0);           // lines 2,3
    slow = 1'b0;
  endtask

  task automatic t_zero;
    log_n = 0;
    wr(2'd1, 32'h1);
    wr(2'd2, 32'd0);
    chk(!busy_o, "R4 zero busy", 32'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk(log_n == 0 && !busy_o, "R4 zero cmds", 32'(log_n), 0);
  endtask

  task automatic t_global;
    log_n = 0;
    wr(2'd1, 32'h1);
    wr(2'd3, 32'h0);
    chk(busy_o, "R8 sweep start", 32'(busy_o), 1);
    wait_idle("R8 sweep end", NF);
    cmp_log("R8 sweep order", NF, '0, 1, 1'b0, 1'b1);
  endtask

  task automatic t_prog;
    run_range("R9 prog inv", 32'h80, 16, 1, 1'b1);
    log_n = 0;
    wr(2'd1, 32'h6);                                       // program + writeback
    wr(2'd2, 32'd16);
    chk(!busy_o, "R9 prog wb refused", 32'(busy_o), 0);
    wr(2'd1, 32'h7);                                       // program + wbinv, sweep
    wr(2'd3, 32'd0);
    chk(!busy_o, "R9 prog sweep refused", 32'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R9 no cmds", 32'(log_n), 0);
  endtask

  task automatic t_busy_ignore;
    slow = 1'b1;
    log_n = 0;
    wr(2'd0, 32'h40);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'd64);                                      // lines 4..7
    wr(2'd0, 32'h400);
    wr(2'd1, 32'h2);
    wr(2'd2, 32'd16);
    wr(2'd3, 32'd0);
    chk(busy_o, "R10 still busy", 32'(busy_o), 1);
    wait_idle("R10 busy end", 4);
    cmp_log("R10 writes ignored", 4, 28'd4, 1, 1'b0, 1'b0);
    slow = 1'b0;
    log_n = 0;
    wr(2'd2, 32'd16);                                      // old base and op remain
    wait_idle("R10 config kept", 1);
    cmp_log("R10 config kept", 1, 28'd4, 1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inv();
    t_wb();
    t_wbinv();
    t_zero();
    t_global();
    t_prog();
    t_busy_ignore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule